// File: doc/BRIEF.md
# Smart Card Channel DMA Flag and Request Controller

This block holds the status flags and the request logic of a half-duplex smart-card serial channel whose characters are moved by a DMA engine. On the transmit side a single data register feeds a character-level line interface. When the card accepts a character, the block raises a transmit request to the DMA engine. The engine answers by writing the next character, and that write also clears the request. When the card rejects a character, the block sends the same character again by itself. It raises no request during these retries, so the DMA engine cannot run ahead of the line.

On the receive side, each clean character sets a receive-full flag, and that flag is the receive request to the DMA engine. A character that arrives with a parity error, or that arrives while the previous one is still unread, only sets a sticky error flag. Error flags stay set until software clears them. Their OR, gated by an enable bit, drives one level-sensitive error interrupt. A retry cap stops a card that keeps rejecting a character from hanging the transfer.

Bit timing, baud generation and guard time belong to the line layer and are not part of this block.

Top module: `sc_dma_flagctl`

## Requirements
- R1: After reset the status word reads 0x01: the data-empty flag (bit 0) is 1 and every other flag is 0. Both DMA requests, the error interrupt and the line start pulse are low.
- R2: A DMA transmit acknowledge, or a CPU write to address 0, loads the character when the data-empty flag is 1. The same edge clears data-empty (bit 0) and transmit-end (bit 1), and the next cycle carries a one-cycle start pulse with that character on the line.
- R3: A line completion without rejection sets data-empty and transmit-end together. The transmit request then rises and stays high until a DMA transmit acknowledge.
- R4: A line completion with rejection starts the same character again on the next cycle. It sets the transmit error flag (bit 3) and keeps transmit-end and the transmit request at 0.
- R5: After MAX_RETRY automatic resends (default 4), a further rejection abandons the character. It sets data-empty, transmit-end and the give-up flag (bit 6), and it starts nothing.
- R6: The transmit error flag is never cleared by hardware, including when later characters complete cleanly.
- R7: A received character without error, while receive-full (bit 2) is 0, is stored on rx_data and sets receive-full, which is the receive request. A DMA receive acknowledge clears it.
- R8: A received character flagged with a parity error sets the parity flag (bit 4). It leaves receive-full, the receive request and rx_data unchanged.
- R9: A clean character that arrives while receive-full is 1 and is not being acknowledged sets the overrun flag (bit 5) and is dropped.
- R10: A flag among bits 3 to 6 is cleared by writing 0 to it at address 2, but only after a read strobe at address 2 has seen it as 1. Writing 1 to a flag bit has no effect.
- R11: The error interrupt is high exactly when the enable bit (address 3, bit 0) is 1 and at least one of flags 3 to 6 is set.
- R12: A write to address 0 while data-empty is 0 is ignored: the character on the line stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing, pops receive data) |
| reg_addr | input | 2 | 0 transmit data, 1 receive data, 2 status, 3 control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational |
| tx_dreq | output | 1 | Transmit DMA request, level |
| dma_tx_ack | input | 1 | DMA write of the next transmit character |
| dma_tx_data | input | DATA_W | Character written by the DMA engine |
| rx_dreq | output | 1 | Receive DMA request, level |
| dma_rx_ack | input | 1 | DMA read of the receive character |
| rx_data | output | DATA_W | Stored receive character |
| err_irq | output | 1 | Error interrupt, level |
| line_tx_start | output | 1 | One-cycle pulse: send line_tx_char |
| line_tx_char | output | DATA_W | Character to send |
| line_tx_done | input | 1 | Line finished the current character |
| line_tx_nak | input | 1 | Card rejected it, valid with line_tx_done |
| line_rx_valid | input | 1 | A character arrived |
| line_rx_char | input | DATA_W | Arrived character |
| line_rx_perr | input | 1 | Arrived character has a parity error |

## Verification
The status flags, the requests and the line start pulse are all registered, so each one changes on the clock edge that captures its stimulus. The bench drives every input on a falling edge and holds it for one rising edge. It then reads the result on the following falling edge, and a start pulse is checked once there and once a cycle later to confirm that it lasts one cycle. The error interrupt and the register read data are combinational from registered state, so they are read on that same falling edge. Hold checks such as a request staying high or a flag surviving an unarmed write are read on later falling edges with no new stimulus in between.

// File: rtl/sc_flag_pkg.sv
// Package: shared register addresses and status bit positions of the
// smart-card channel flag controller. Assumes a data width of at least 8.
package sc_flag_pkg;

    typedef enum logic [1:0] {
        RA_TXD  = 2'd0,
        RA_RXD  = 2'd1,
        RA_STAT = 2'd2,
        RA_CTRL = 2'd3
    } sc_addr_e;

    // Status word bit positions
    localparam int unsigned SB_TDE    = 0;
    localparam int unsigned SB_TEND   = 1;
    localparam int unsigned SB_RXF    = 2;
    localparam int unsigned SB_ERR_LO = 3;   // first sticky error flag

    // Sticky error flag indices (status bit = SB_ERR_LO + index)
    localparam int unsigned EF_TXERR  = 0;
    localparam int unsigned EF_PERR   = 1;
    localparam int unsigned EF_OVR    = 2;
    localparam int unsigned EF_GIVEUP = 3;
    localparam int unsigned ERR_N     = 4;

endpackage

// File: rtl/sc_tx_ctl.sv
// Transmit side: one data register, automatic resend on card rejection,
// retry cap, and the data-empty / transmit-end flags.
// Assumes line_done is only raised while a character is in flight.
module sc_tx_ctl #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MAX_RETRY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_data,
    input  logic              line_done,
    input  logic              line_nak,
    output logic              tde,
    output logic              tend,
    output logic              start,
    output logic [DATA_W-1:0] tx_char,
    output logic              err_set,
    output logic              giveup_set
);

    localparam int unsigned RETRY_W = $clog2(MAX_RETRY + 1);
    localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_W'(MAX_RETRY);

    logic [RETRY_W-1:0] retries;
    logic               in_flight;
    logic               rejected;
    logic               load_ok;

    // Decode the events of this cycle
    always_comb begin
        in_flight  = ~tde;
        load_ok    = load_req & tde;
        rejected   = in_flight & line_done & line_nak;
        err_set    = rejected;
        giveup_set = rejected & (retries == RETRY_LAST);
    end

    // Character load, completion, resend and abandon sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_char <= '0;
            tde     <= 1'b1;
            tend    <= 1'b0;
            start   <= 1'b0;
            retries <= '0;
        end else begin
            start <= 1'b0;
            if (load_ok) begin
                tx_char <= load_data;
                tde     <= 1'b0;
                tend    <= 1'b0;
                retries <= '0;
                start   <= 1'b1;
            end else if (in_flight && line_done) begin
                if (!line_nak || giveup_set) begin
                    tde  <= 1'b1;
                    tend <= 1'b1;
                end else begin
                    retries <= retries + 1'b1;
                    start   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sc_rx_ctl.sv
// Receive side: receive data register, receive-full flag, and the
// parity-error and overrun set pulses. A take (DMA acknowledge or CPU
// read) in the same cycle as a new clean character frees the register.
module sc_rx_ctl #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              perr,
    input  logic              take,
    output logic              rxf,
    output logic [DATA_W-1:0] rdr,
    output logic              perr_set,
    output logic              ovr_set
);

    logic clean;
    logic room;

    // Classify the arriving character
    always_comb begin
        clean    = valid & ~perr;
        room     = ~rxf | take;
        perr_set = valid & perr;
        ovr_set  = clean & ~room;
    end

    // Store clean characters and track receive-full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxf <= 1'b0;
            rdr <= '0;
        end else if (clean && room) begin
            rdr <= rx_char;
            rxf <= 1'b1;
        end else if (take) begin
            rxf <= 1'b0;
        end
    end

endmodule

// File: rtl/sc_flag_regs.sv
// Sticky error flags with read-then-write-zero clearing, the error
// interrupt enable, and the interrupt level. Hardware set wins over a
// clear in the same cycle.
module sc_flag_regs #(
    parameter int unsigned ERR_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_N-1:0] err_set,
    input  logic             stat_rd,
    input  logic             stat_wr,
    input  logic [ERR_N-1:0] stat_wbits,
    input  logic             ctrl_wr,
    input  logic             ctrl_en,
    output logic [ERR_N-1:0] err_q,
    output logic             irq_en,
    output logic             err_irq
);

    logic [ERR_N-1:0] armed;

    // One flag cell per sticky error bit
    for (genvar gi = 0; gi < ERR_N; gi++) begin : g_flag
        logic clr;

        // Clear request: armed by a read as 1, then written 0
        always_comb clr = stat_wr & armed[gi] & ~stat_wbits[gi];

        // Flag and arm state of this bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_q[gi] <= 1'b0;
                armed[gi] <= 1'b0;
            end else begin
                if (err_set[gi]) begin
                    err_q[gi] <= 1'b1;
                end else if (clr) begin
                    err_q[gi] <= 1'b0;
                end
                if (clr) begin
                    armed[gi] <= 1'b0;
                end else if (stat_rd && err_q[gi]) begin
                    armed[gi] <= 1'b1;
                end
            end
        end
    end

    // Error interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en <= ctrl_en;
        end
    end

    // Level interrupt from the enabled flags
    always_comb err_irq = irq_en & (|err_q);

endmodule

// File: rtl/sc_dma_flagctl.sv
// Top: register decode, status word assembly and DMA request wiring
// for the smart-card channel. Assumes DATA_W >= 8 so the status word fits.
module sc_dma_flagctl
    import sc_flag_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MAX_RETRY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_dreq,
    input  logic              dma_tx_ack,
    input  logic [DATA_W-1:0] dma_tx_data,
    output logic              rx_dreq,
    input  logic              dma_rx_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              err_irq,
    output logic              line_tx_start,
    output logic [DATA_W-1:0] line_tx_char,
    input  logic              line_tx_done,
    input  logic              line_tx_nak,
    input  logic              line_rx_valid,
    input  logic [DATA_W-1:0] line_rx_char,
    input  logic              line_rx_perr
);

    logic              tde, tend, rxf, irq_en;
    logic              load_req;
    logic [DATA_W-1:0] load_data;
    logic              rx_take;
    logic              tx_err_set, tx_giveup_set, rx_perr_set, rx_ovr_set;
    logic [ERR_N-1:0]  err_set, err_q;
    logic              stat_rd, stat_wr, ctrl_wr;
    logic [DATA_W-1:0] stat_word;

    // Register port decode and DMA acknowledge merging
    always_comb begin
        stat_rd   = reg_rd & (reg_addr == RA_STAT);
        stat_wr   = reg_wr & (reg_addr == RA_STAT);
        ctrl_wr   = reg_wr & (reg_addr == RA_CTRL);
        load_req  = dma_tx_ack | (reg_wr & (reg_addr == RA_TXD));
        load_data = dma_tx_ack ? dma_tx_data : reg_wdata;
        rx_take   = dma_rx_ack | (reg_rd & (reg_addr == RA_RXD));
    end

    // Route hardware error events to their sticky flags
    always_comb begin
        err_set            = '0;
        err_set[EF_TXERR]  = tx_err_set;
        err_set[EF_PERR]   = rx_perr_set;
        err_set[EF_OVR]    = rx_ovr_set;
        err_set[EF_GIVEUP] = tx_giveup_set;
    end

    sc_tx_ctl #(.DATA_W(DATA_W), .MAX_RETRY(MAX_RETRY)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_req),
        .load_data  (load_data),
        .line_done  (line_tx_done),
        .line_nak   (line_tx_nak),
        .tde        (tde),
        .tend       (tend),
        .start      (line_tx_start),
        .tx_char    (line_tx_char),
        .err_set    (tx_err_set),
        .giveup_set (tx_giveup_set)
    );

    sc_rx_ctl #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (line_rx_valid),
        .rx_char  (line_rx_char),
        .perr     (line_rx_perr),
        .take     (rx_take),
        .rxf      (rxf),
        .rdr      (rx_data),
        .perr_set (rx_perr_set),
        .ovr_set  (rx_ovr_set)
    );

    sc_flag_regs #(.ERR_N(ERR_N)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_set    (err_set),
        .stat_rd    (stat_rd),
        .stat_wr    (stat_wr),
        .stat_wbits (reg_wdata[SB_ERR_LO +: ERR_N]),
        .ctrl_wr    (ctrl_wr),
        .ctrl_en    (reg_wdata[0]),
        .err_q      (err_q),
        .irq_en     (irq_en),
        .err_irq    (err_irq)
    );

    // Requests follow the end-of-character and receive-full flags
    always_comb begin
        tx_dreq = tend;
        rx_dreq = rxf;
    end

    // Status word and read data mux
    always_comb begin
        stat_word                     = '0;
        stat_word[SB_TDE]             = tde;
        stat_word[SB_TEND]            = tend;
        stat_word[SB_RXF]             = rxf;
        stat_word[SB_ERR_LO +: ERR_N] = err_q;
        case (reg_addr)
            RA_RXD:  reg_rdata = rx_data;
            RA_STAT: reg_rdata = stat_word;
            RA_CTRL: reg_rdata = {{(DATA_W-1){1'b0}}, irq_en};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sc_dma_flagctl_chk.sv
// Checker: temporal properties of the flag controller, bound to the top.
// Assumes line_tx_done is raised only while a character is in flight.
module sc_dma_flagctl_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_dreq,
    input logic dma_tx_ack,
    input logic rx_dreq,
    input logic dma_rx_ack,
    input logic line_rx_valid,
    input logic line_rx_perr,
    input logic line_tx_start,
    input logic line_tx_done,
    input logic line_tx_nak,
    input logic err_irq,
    input logic irq_en
);

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_tx_start |=> !line_tx_start);

    p_req_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_dreq) |-> $past(line_tx_done));

    p_ack_drops_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dreq && dma_tx_ack) |=> !tx_dreq);

    p_reject_resends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tx_done && line_tx_nak && !tx_dreq) |=> (line_tx_start ^ tx_dreq));

    p_rx_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dreq && dma_rx_ack && !line_rx_valid) |=> !rx_dreq);

    p_perr_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rx_valid && line_rx_perr && !rx_dreq) |=> !rx_dreq);

    p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> irq_en);

endmodule

bind sc_dma_flagctl sc_dma_flagctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_dreq       (tx_dreq),
    .dma_tx_ack    (dma_tx_ack),
    .rx_dreq       (rx_dreq),
    .dma_rx_ack    (dma_rx_ack),
    .line_rx_valid (line_rx_valid),
    .line_rx_perr  (line_rx_perr),
    .line_tx_start (line_tx_start),
    .line_tx_done  (line_tx_done),
    .line_tx_nak   (line_tx_nak),
    .err_irq       (err_irq),
    .irq_en        (irq_en)
);

// File: tb/sim_sc_dma_flagctl.sv
`timescale 1ns/1ps
// Bench: receive vector table walked by one loop, then directed
// transmit, retry-cap, flag-clearing and interrupt tests.
module sim_sc_dma_flagctl;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = 2'd2;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          tx_dreq, rx_dreq, err_irq, line_tx_start;
    logic          dma_tx_ack = 1'b0, dma_rx_ack = 1'b0;
    logic [DW-1:0] dma_tx_data = '0;
    logic [DW-1:0] rx_data, line_tx_char;
    logic          line_tx_done = 1'b0, line_tx_nak = 1'b0;
    logic          line_rx_valid = 1'b0, line_rx_perr = 1'b0;
    logic [DW-1:0] line_rx_char = '0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    sc_dma_flagctl #(.DATA_W(DW), .MAX_RETRY(4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_dreq(tx_dreq), .dma_tx_ack(dma_tx_ack), .dma_tx_data(dma_tx_data),
        .rx_dreq(rx_dreq), .dma_rx_ack(dma_rx_ack), .rx_data(rx_data),
        .err_irq(err_irq), .line_tx_start(line_tx_start),
        .line_tx_char(line_tx_char), .line_tx_done(line_tx_done),
        .line_tx_nak(line_tx_nak), .line_rx_valid(line_rx_valid),
        .line_rx_char(line_rx_char), .line_rx_perr(line_rx_perr)
    );

    // Receive vectors: perr, ack, char, expected rxf, data, perr flag, ovr flag
    typedef struct packed {
        logic          perr;
        logic          ack;
        logic [DW-1:0] ch;
        logic          e_rxf;
        logic [DW-1:0] e_data;
        logic          e_perr;
        logic          e_ovr;
    } rxv_t;

    localparam rxv_t RXV [5] = '{
        '{1'b0, 1'b1, 8'h3C, 1'b1, 8'h3C, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'hA5, 1'b1, 8'hA5, 1'b0, 1'b0},
        '{1'b0, 1'b1, 8'h11, 1'b1, 8'hA5, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'h77, 1'b0, 8'hA5, 1'b1, 1'b1},
        '{1'b0, 1'b1, 8'h42, 1'b1, 8'h42, 1'b1, 1'b1}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [DW-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic cpu_rd_stat();
        reg_addr = 2'd2; reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic tx_end(input logic nak);
        line_tx_done = 1'b1; line_tx_nak = nak;
        step();
        line_tx_done = 1'b0; line_tx_nak = 1'b0;
    endtask

    task automatic dma_tx(input logic [DW-1:0] d);
        dma_tx_ack = 1'b1; dma_tx_data = d;
        step();
        dma_tx_ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", 32'(reg_rdata), 32'h01);
        chk("R1 tx_dreq", 32'(tx_dreq), 0);
        chk("R1 rx_dreq", 32'(rx_dreq), 0);
        chk("R1 err_irq", 32'(err_irq), 0);
        chk("R1 start", 32'(line_tx_start), 0);

        // R7 R8 R9 receive vector table
        for (int i = 0; i < 5; i++) begin
            line_rx_valid = 1'b1; line_rx_perr = RXV[i].perr; line_rx_char = RXV[i].ch;
            step();
            line_rx_valid = 1'b0; line_rx_perr = 1'b0;
            chk("R7 R9 rx_dreq", 32'(rx_dreq), 32'(RXV[i].e_rxf));
            chk("R7 R8 R9 rx_data", 32'(rx_data), 32'(RXV[i].e_data));
            chk("R8 perr flag", 32'(reg_rdata[4]), 32'(RXV[i].e_perr));
            chk("R9 ovr flag", 32'(reg_rdata[5]), 32'(RXV[i].e_ovr));
            if (RXV[i].ack) begin
                dma_rx_ack = 1'b1;
                step();
                dma_rx_ack = 1'b0;
                chk("R7 ack clears", 32'(rx_dreq), 0);
            end
        end

        // R2 CPU load of first character
        cpu_wr(2'd0, 8'h5A);
        chk("R2 start", 32'(line_tx_start), 1);
        chk("R2 char", 32'(line_tx_char), 32'h5A);
        chk("R2 flags", 32'(reg_rdata[1:0]), 0);
        step();
        chk("R2 one-cycle start", 32'(line_tx_start), 0);

        // R12 write while busy ignored
        cpu_wr(2'd0, 8'hFF);
        chk("R12 char kept", 32'(line_tx_char), 32'h5A);
        chk("R12 no start", 32'(line_tx_start), 0);

        // R3 clean completion raises the request and holds it
        tx_end(1'b0);
        chk("R3 tx_dreq", 32'(tx_dreq), 1);
        chk("R3 flags", 32'(reg_rdata[1:0]), 3);
        step(); step();
        chk("R3 held", 32'(tx_dreq), 1);
        dma_tx(8'h81);
        chk("R3 ack drops", 32'(tx_dreq), 0);
        chk("R2 dma start", 32'(line_tx_start), 1);
        chk("R2 dma char", 32'(line_tx_char), 32'h81);

        // R4 rejection resends the same character
        step();
        tx_end(1'b1);
        chk("R4 restart", 32'(line_tx_start), 1);
        chk("R4 char", 32'(line_tx_char), 32'h81);
        chk("R4 no req", 32'(tx_dreq), 0);
        chk("R4 tend", 32'(reg_rdata[1]), 0);
        chk("R4 txerr", 32'(reg_rdata[3]), 1);

        // R6 flag survives a clean completion
        step();
        tx_end(1'b0);
        chk("R6 req", 32'(tx_dreq), 1);
        chk("R6 txerr kept", 32'(reg_rdata[3]), 1);

        // R5 retry cap
        dma_tx(8'h22);
        for (int k = 0; k < 4; k++) begin
            step();
            tx_end(1'b1);
            chk("R5 resend", 32'(line_tx_start), 1);
            chk("R5 no req", 32'(tx_dreq), 0);
        end
        step();
        tx_end(1'b1);
        chk("R5 no start", 32'(line_tx_start), 0);
        chk("R5 req", 32'(tx_dreq), 1);
        chk("R5 flags", 32'(reg_rdata[1:0]), 3);
        chk("R5 giveup", 32'(reg_rdata[6]), 1);

        // R11 interrupt gating
        chk("R11 disabled", 32'(err_irq), 0);
        cpu_wr(2'd3, 8'h01);
        chk("R11 enabled", 32'(err_irq), 1);

        // R10 clearing protocol
        cpu_wr(2'd2, 8'h00);
        chk("R10 unarmed write", 32'(reg_rdata[6:3]), 32'hF);
        cpu_rd_stat();
        cpu_wr(2'd2, 8'hFF);
        chk("R10 write ones", 32'(reg_rdata[6:3]), 32'hF);
        cpu_wr(2'd2, 8'hF7);
        chk("R10 clear txerr only", 32'(reg_rdata[6:3]), 32'hE);
        cpu_wr(2'd2, 8'h00);
        chk("R10 clear rest", 32'(reg_rdata[6:3]), 0);
        chk("R11 irq low", 32'(err_irq), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule